// File: doc/BRIEF.md
# Paged Coefficient Register Bank

This block holds the programmable coefficients of a cascade of second-order filter sections. It presents them to software as byte registers spread over several pages, and to the filter datapath as one flat bus of 32-bit words. A byte bus reaches it with a write strobe, a read strobe, a 7-bit address, write data and read data. A `seq` qualifier picks either the address on the port or the block's own running pointer. A run of `seq` accesses therefore forms a burst that walks the byte space with no new address.

Every page has a page-select byte at address 0x00. On the coefficient pages, bytes 0x08 to 0x7F hold six filter sections of five coefficients each. A burst that runs off the top of one coefficient page carries on at the first coefficient byte of the next page and moves the page selector with it, so one long transfer can load every section. The control input `cross_dis` turns this page crossing off. The burst then folds back to the first coefficient byte of the same page.

Top module: `coef_bank`

## Requirements
- R1: After reset the page selector is 0x00. Every first coefficient (N0) of every section reads 0x7FFFFFFF on `coef_o` and every other coefficient reads 0x00000000. The coefficient pages are 2, 3 and 4.
- R2: A write to address 0x00 loads `wdata` into the page selector at the next edge, on any page. A read of address 0x00 returns the page selector.
- R3: On a coefficient page, byte address A in 0x08..0x7F maps to local offset A-0x08. Section = offset/20, coefficient = (offset%20)/4 in the order N0, N1, N2, D1, D2, and byte = offset%4 with byte 0 the most significant. The word sits at `coef_o[idx*32 +: 32]` with idx = ((page-2)*6 + section)*5 + coefficient.
- R4: `rdata` shows the addressed byte combinationally in the cycle `rd_en` is high and is 0x00 while `rd_en` is low. A write takes effect at the next clock edge. A read and a write in the same cycle return the old byte. `coef_o` does not change in a cycle without a write.
- R5: The effective address is `addr` when `seq`=0 and the internal pointer when `seq`=1. After any access that is not a page crossing or fold, the pointer becomes the effective address plus one. Without an access the pointer and page selector hold.
- R6: With `cross_dis`=0, an access to 0x7F on page 2 or 3 moves the page selector to the next page and sets the pointer to 0x08.
- R7: An access to 0x7F on page 4, or on any coefficient page while `cross_dis`=1, sets the pointer to 0x08 and leaves the page selector unchanged.
- R8: On coefficient pages, addresses 0x01..0x07 read 0x00 and writes to them change nothing.
- R9: On a page other than 2, 3 or 4, every address except 0x00 reads 0x00 and ignores writes. The pointer there wraps from 0x7F to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| seq | input | 1 | 1: use internal burst pointer, 0: use `addr` |
| cross_dis | input | 1 | 1: burst folds within the page instead of crossing |
| addr | input | 7 | Byte address for non-burst access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| coef_o | output | 2880 | All coefficients, 32 bits each, index per R3 |

## Verification
The bench builds the block with its default parameters: three coefficient pages starting at page 2, six sections of five 4-byte coefficients, and a base offset of 0x08. These values put the top byte at exactly 0x7F. Both the crossing from page 2 to 3 and from 3 to 4 can then be reached, as well as the fold on the last page, all with real 7-bit addresses. The same values make the flat-bus index of a written byte computable by hand, so the bench can check that bursts land in the right word of `coef_o`.

// File: rtl/coef_bank_pkg.sv
package coef_bank_pkg;

    localparam int ADDR_W = 7;
    localparam int BYTE_W = 8;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BYTE_W-1:0] byte_t;

    // One bus access as seen by the sequencer.
    typedef struct packed {
        logic  wr;
        logic  rd;
        logic  seq;
        addr_t addr;
        byte_t wdata;
    } bus_req_t;

    // How the burst pointer moves after an access.
    typedef enum logic [1:0] {
        STEP_NONE,
        STEP_LINEAR,
        STEP_CROSS,
        STEP_FOLD
    } step_e;

    // Reset value of the byte at a local offset inside a coefficient page:
    // the first coefficient of each section is the largest positive value.
    function automatic byte_t reset_byte(int unsigned idx, int unsigned bpc, int unsigned cps);
        int unsigned coef_in_sec;
        int unsigned byte_in_coef;
        coef_in_sec  = (idx / bpc) % cps;
        byte_in_coef = idx % bpc;
        if (coef_in_sec != 0) return '0;
        return (byte_in_coef == 0) ? 8'h7F : 8'hFF;
    endfunction

endpackage

// File: rtl/coef_bank_seq.sv
module coef_bank_seq
    import coef_bank_pkg::*;
#(
    parameter int FIRST_PAGE = 2,
    parameter int NUM_PAGES  = 3,
    parameter int BASE_ADDR  = 8,
    parameter int TOP_ADDR   = 127
) (
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    input  logic     cross_dis,
    output addr_t    eff_addr,
    output addr_t    ptr_q,
    output byte_t    page_q
);
    localparam byte_t PG_LO  = byte_t'(FIRST_PAGE);
    localparam byte_t PG_HI  = byte_t'(FIRST_PAGE + NUM_PAGES - 1);
    localparam addr_t A_BASE = addr_t'(BASE_ADDR);
    localparam addr_t A_TOP  = addr_t'(TOP_ADDR);

    logic  access;
    logic  page_wr;
    logic  on_coef;
    step_e step;

    always_comb begin
        eff_addr = req.seq ? ptr_q : req.addr;
        access   = req.wr | req.rd;
        page_wr  = req.wr && (eff_addr == '0);
        on_coef  = (page_q >= PG_LO) && (page_q <= PG_HI);
        if (!access)
            step = STEP_NONE;
        else if (on_coef && eff_addr == A_TOP)
            step = (!cross_dis && page_q != PG_HI) ? STEP_CROSS : STEP_FOLD;
        else
            step = STEP_LINEAR;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
            ptr_q  <= '0;
        end else begin
            case (step)
                STEP_LINEAR: ptr_q <= eff_addr + addr_t'(1);
                STEP_CROSS: begin
                    ptr_q  <= A_BASE;
                    page_q <= page_q + byte_t'(1);
                end
                STEP_FOLD:   ptr_q <= A_BASE;
                default:     ptr_q <= ptr_q;
            endcase
            if (page_wr)
                page_q <= req.wdata;
        end
    end

endmodule

// File: rtl/coef_bank_store.sv
module coef_bank_store
    import coef_bank_pkg::*;
#(
    parameter int FIRST_PAGE     = 2,
    parameter int NUM_PAGES      = 3,
    parameter int SECTIONS       = 6,
    parameter int COEFS_PER_SEC  = 5,
    parameter int BYTES_PER_COEF = 4,
    parameter int BASE_ADDR      = 8,
    localparam int COEF_W        = BYTES_PER_COEF * BYTE_W,
    localparam int COEFS_PER_PG  = SECTIONS * COEFS_PER_SEC,
    localparam int NUM_COEFS     = NUM_PAGES * COEFS_PER_PG
) (
    input  logic                        clk,
    input  logic                        rst,
    input  byte_t                       page,
    input  addr_t                       eff_addr,
    input  logic                        wr,
    input  byte_t                       wdata,
    output byte_t                       rd_byte,
    output logic [NUM_COEFS*COEF_W-1:0] coef_o
);
    localparam int BYTES_PER_PG = COEFS_PER_PG * BYTES_PER_COEF;
    localparam int OFF_W        = $clog2(BYTES_PER_PG);
    localparam int PG_W         = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;
    localparam byte_t PG_LO     = byte_t'(FIRST_PAGE);
    localparam byte_t PG_HI     = byte_t'(FIRST_PAGE + NUM_PAGES - 1);
    localparam addr_t A_BASE    = addr_t'(BASE_ADDR);
    localparam addr_t A_TOP     = addr_t'(BASE_ADDR + BYTES_PER_PG - 1);

    logic            hit;
    logic [OFF_W-1:0] off_idx;
    logic [PG_W-1:0]  pg_idx;
    byte_t           pg_rd [NUM_PAGES];

    always_comb begin
        hit     = (page >= PG_LO) && (page <= PG_HI) &&
                  (eff_addr >= A_BASE) && (eff_addr <= A_TOP);
        off_idx = OFF_W'(eff_addr - A_BASE);
        pg_idx  = PG_W'(page - PG_LO);
    end

    for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
        byte_t mem [BYTES_PER_PG];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < BYTES_PER_PG; i++)
                    mem[i] <= reset_byte(i, BYTES_PER_COEF, COEFS_PER_SEC);
            end else if (wr && hit && pg_idx == PG_W'(p)) begin
                mem[off_idx] <= wdata;
            end
        end

        assign pg_rd[p] = hit ? mem[off_idx] : '0;

        for (genvar c = 0; c < COEFS_PER_PG; c++) begin : g_coef
            for (genvar b = 0; b < BYTES_PER_COEF; b++) begin : g_byte
                assign coef_o[(p*COEFS_PER_PG + c)*COEF_W + (BYTES_PER_COEF-1-b)*BYTE_W +: BYTE_W]
                    = mem[c*BYTES_PER_COEF + b];
            end
        end
    end

    assign rd_byte = hit ? pg_rd[pg_idx] : '0;

endmodule

// File: rtl/coef_bank.sv
module coef_bank
    import coef_bank_pkg::*;
#(
    parameter int FIRST_PAGE     = 2,
    parameter int NUM_PAGES      = 3,
    parameter int SECTIONS       = 6,
    parameter int COEFS_PER_SEC  = 5,
    parameter int BYTES_PER_COEF = 4,
    parameter int BASE_ADDR      = 8,
    localparam int COEF_W        = BYTES_PER_COEF * BYTE_W,
    localparam int NUM_COEFS     = NUM_PAGES * SECTIONS * COEFS_PER_SEC,
    localparam int TOP_ADDR      = BASE_ADDR + SECTIONS * COEFS_PER_SEC * BYTES_PER_COEF - 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic                        seq,
    input  logic                        cross_dis,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [BYTE_W-1:0]           wdata,
    output logic [BYTE_W-1:0]           rdata,
    output logic [NUM_COEFS*COEF_W-1:0] coef_o
);
    bus_req_t req;
    addr_t    eff_addr;
    addr_t    ptr_q;
    byte_t    page_q;
    byte_t    store_byte;

    assign req = '{wr: wr_en, rd: rd_en, seq: seq, addr: addr, wdata: wdata};

    coef_bank_seq #(
        .FIRST_PAGE(FIRST_PAGE),
        .NUM_PAGES (NUM_PAGES),
        .BASE_ADDR (BASE_ADDR),
        .TOP_ADDR  (TOP_ADDR)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .cross_dis(cross_dis),
        .eff_addr (eff_addr),
        .ptr_q    (ptr_q),
        .page_q   (page_q)
    );

    coef_bank_store #(
        .FIRST_PAGE    (FIRST_PAGE),
        .NUM_PAGES     (NUM_PAGES),
        .SECTIONS      (SECTIONS),
        .COEFS_PER_SEC (COEFS_PER_SEC),
        .BYTES_PER_COEF(BYTES_PER_COEF),
        .BASE_ADDR     (BASE_ADDR)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .page    (page_q),
        .eff_addr(eff_addr),
        .wr      (wr_en),
        .wdata   (wdata),
        .rd_byte (store_byte),
        .coef_o  (coef_o)
    );

    always_comb begin
        if (!rd_en)
            rdata = '0;
        else if (eff_addr == '0)
            rdata = page_q;
        else
            rdata = store_byte;
    end

endmodule

// File: rtl/coef_bank_chk.sv
module coef_bank_chk
    import coef_bank_pkg::*;
#(
    parameter int FIRST_PAGE = 2,
    parameter int NUM_PAGES  = 3,
    parameter int BASE_ADDR  = 8,
    parameter int TOP_ADDR   = 127,
    parameter int OUT_W      = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             rd_en,
    input logic             cross_dis,
    input logic [7:0]       wdata,
    input logic [7:0]       rdata,
    input addr_t            eff_addr,
    input addr_t            ptr_q,
    input byte_t            page_q,
    input logic [OUT_W-1:0] coef_o
);
    localparam byte_t PG_LO  = byte_t'(FIRST_PAGE);
    localparam byte_t PG_HI  = byte_t'(FIRST_PAGE + NUM_PAGES - 1);
    localparam addr_t A_BASE = addr_t'(BASE_ADDR);
    localparam addr_t A_TOP  = addr_t'(TOP_ADDR);

    logic acc;
    logic on_coef;
    assign acc     = wr_en | rd_en;
    assign on_coef = (page_q >= PG_LO) && (page_q <= PG_HI);

    AST_PAGE_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && eff_addr == '0) |=> page_q == $past(wdata)); // R2

    AST_READ_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> rdata == '0); // R4

    AST_COEF_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(coef_o)); // R4

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (acc && !(on_coef && eff_addr == A_TOP)) |=> ptr_q == $past(eff_addr) + addr_t'(1)); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !acc |=> ($stable(ptr_q) && $stable(page_q))); // R5

    AST_PAGE_CROSS: assert property (@(posedge clk) disable iff (rst)
        (acc && on_coef && eff_addr == A_TOP && !cross_dis && page_q != PG_HI)
        |=> (page_q == $past(page_q) + byte_t'(1) && ptr_q == A_BASE)); // R6

    AST_PAGE_FOLD: assert property (@(posedge clk) disable iff (rst)
        (acc && on_coef && eff_addr == A_TOP && (cross_dis || page_q == PG_HI))
        |=> (page_q == $past(page_q) && ptr_q == A_BASE)); // R7

    AST_GAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && on_coef && eff_addr != '0 && eff_addr < A_BASE) |-> rdata == '0); // R8

    AST_FOREIGN_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !on_coef && eff_addr != '0) |-> rdata == '0); // R9

endmodule

bind coef_bank coef_bank_chk #(
    .FIRST_PAGE(FIRST_PAGE),
    .NUM_PAGES (NUM_PAGES),
    .BASE_ADDR (BASE_ADDR),
    .TOP_ADDR  (TOP_ADDR),
    .OUT_W     (NUM_COEFS*COEF_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .cross_dis(cross_dis),
    .wdata    (wdata),
    .rdata    (rdata),
    .eff_addr (eff_addr),
    .ptr_q    (ptr_q),
    .page_q   (page_q),
    .coef_o   (coef_o)
);

// File: tb/sim_coef_bank.sv
module sim_coef_bank;
    localparam int NC = 3 * 6 * 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0, rd_en = 1'b0, seq = 1'b0, cross_dis = 1'b0;
    logic [6:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [NC*32-1:0] coef_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    coef_bank u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .seq(seq),
        .cross_dis(cross_dis), .addr(addr), .wdata(wdata), .rdata(rdata),
        .coef_o(coef_o)
    );

    typedef struct packed {
        bit       wr;
        bit       rd;
        bit       sq;
        bit [6:0] a;
        bit [7:0] d;
        bit [7:0] exp;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 1'b0, 7'h00, 8'h02, 8'h00}, // R2 select page 2; R4 rdata 0 when not reading
        '{1'b0, 1'b1, 1'b0, 7'h00, 8'h00, 8'h02}, // R2 read back selector
        '{1'b0, 1'b1, 1'b0, 7'h08, 8'h00, 8'h7F}, // R1 N0 top byte
        '{1'b0, 1'b1, 1'b1, 7'h00, 8'h00, 8'hFF}, // R5 burst 0x09
        '{1'b0, 1'b1, 1'b1, 7'h00, 8'h00, 8'hFF}, // R5 burst 0x0A
        '{1'b0, 1'b1, 1'b1, 7'h00, 8'h00, 8'hFF}, // R5 burst 0x0B
        '{1'b0, 1'b1, 1'b1, 7'h00, 8'h00, 8'h00}, // R3 N1 starts at 0x0C
        '{1'b1, 1'b0, 1'b0, 7'h1C, 8'h12, 8'h00}, // R3 section 1 N0
        '{1'b1, 1'b0, 1'b1, 7'h00, 8'h34, 8'h00}, // R5 burst write
        '{1'b1, 1'b0, 1'b1, 7'h00, 8'h56, 8'h00}, // R5
        '{1'b1, 1'b0, 1'b1, 7'h00, 8'h78, 8'h00}, // R5
        '{1'b0, 1'b1, 1'b0, 7'h1C, 8'h00, 8'h12}, // R4 written byte visible
        '{1'b0, 1'b1, 1'b1, 7'h00, 8'h00, 8'h34}, // R5 pointer after fresh start
        '{1'b1, 1'b0, 1'b0, 7'h03, 8'hAA, 8'h00}, // R8 write to gap
        '{1'b0, 1'b1, 1'b0, 7'h03, 8'h00, 8'h00}, // R8 gap reads zero
        '{1'b1, 1'b1, 1'b0, 7'h20, 8'h99, 8'h00}, // R4 read+write returns old byte
        '{1'b0, 1'b1, 1'b0, 7'h20, 8'h00, 8'h99}  // R4 new byte after edge
    };

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(bit w, bit r, bit s, bit [6:0] a, bit [7:0] d, output logic [7:0] got);
        @(negedge clk);
        wr_en = w; rd_en = r; seq = s; addr = a; wdata = d;
        #1 got = rdata;
        @(posedge clk);
        #1;
        wr_en = 1'b0; rd_en = 1'b0; seq = 1'b0;
    endtask

    function automatic logic [31:0] coef(int i);
        return coef_o[i*32 +: 32];
    endfunction

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] g;
        logic [NC*32-1:0] snap;
        int bad;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset contents on the flat bus
        @(negedge clk);
        bad = 0;
        for (int i = 0; i < NC; i++)
            if (coef(i) !== ((i % 5 == 0) ? 32'h7FFFFFFF : 32'h0)) bad++;
        chk("R1 reset coefficients mismatching", bad, 0);
        acc(0, 1, 0, 7'h00, 8'h00, g);
        chk("R1 reset page selector", g, 8'h00);

        for (int k = 0; k < NV; k++) begin
            acc(VEC[k].wr, VEC[k].rd, VEC[k].sq, VEC[k].a, VEC[k].d, g);
            chk($sformatf("table entry %0d (R1..R8 per comment)", k), g, VEC[k].exp);
        end

        @(negedge clk);
        chk("R3 section 1 N0 word", coef(5), 32'h12345678);
        chk("R3 section 1 N1 word", coef(6), 32'h99000000);

        // R6 read burst crossing 2 -> 3
        acc(1, 0, 0, 7'h00, 8'h02, g);
        acc(0, 1, 0, 7'h7F, 8'h00, g);
        chk("R6 page2 top byte", g, 8'h00);
        acc(0, 1, 1, 7'h00, 8'h00, g);
        chk("R6 crossed read lands on page3 0x08", g, 8'h7F);
        acc(0, 1, 0, 7'h00, 8'h00, g);
        chk("R6 selector advanced", g, 8'h03);

        // R6 write burst crossing 3 -> 4
        acc(1, 0, 0, 7'h7F, 8'h11, g);
        acc(1, 0, 1, 7'h00, 8'h22, g);
        @(negedge clk);
        chk("R6 page3 last word", coef(59), 32'h00000011);
        chk("R6 page4 first word after crossing", coef(60), 32'h22FFFFFF);

        // R7 fold on last page
        acc(0, 1, 0, 7'h7F, 8'h00, g);
        acc(0, 1, 1, 7'h00, 8'h00, g);
        chk("R7 last page folds to 0x08", g, 8'h22);
        acc(0, 1, 0, 7'h00, 8'h00, g);
        chk("R7 selector stays 4", g, 8'h04);

        // R7 fold with crossing disabled
        cross_dis = 1'b1;
        acc(1, 0, 0, 7'h00, 8'h02, g);
        acc(0, 1, 0, 7'h7F, 8'h00, g);
        acc(0, 1, 1, 7'h00, 8'h00, g);
        chk("R7 disabled crossing folds to page2 0x08", g, 8'h7F);
        acc(0, 1, 0, 7'h00, 8'h00, g);
        chk("R7 selector stays 2", g, 8'h02);
        cross_dis = 1'b0;

        // R9 non-coefficient page
        @(negedge clk);
        snap = coef_o;
        acc(1, 0, 0, 7'h00, 8'h05, g);
        acc(1, 0, 0, 7'h10, 8'h55, g);
        acc(0, 1, 0, 7'h10, 8'h00, g);
        chk("R9 foreign page reads zero", g, 8'h00);
        @(negedge clk);
        chk("R9 foreign write left coefficients", (coef_o === snap) ? 32'd1 : 32'd0, 32'd1);
        acc(0, 1, 0, 7'h7F, 8'h00, g);
        acc(0, 1, 1, 7'h00, 8'h00, g);
        chk("R9 pointer wraps to 0x00 selector", g, 8'h05);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule